// File: doc/BRIEF.md
# I2S to Simultaneous-Input DAC Bridge

The bridge accepts a two-channel I2S stream carrying 16-bit samples and drives a DAC whose left and right words enter on two separate serial pins. The two pins share one shift clock, and a separate latch strobe updates the DAC outputs. Every I2S input is oversampled in the fast master clock domain. Each completed stereo pair is handed to an output sequencer, which shifts both words out at the same time in one short burst. The data pins then stay quiet for a programmed number of master cycles. Only after that wait does the sequencer raise its latch strobe, so the analog outputs change while no data line is switching.

The bit clock and word select only frame the incoming data. They play no part in the timing of the latch strobe. That timing comes solely from the master clock and two run-time count inputs: one sets the quiet wait and one sets the strobe width. A pair that arrives while the previous one is still being shifted, settled or latched replaces any pair already waiting, and the bridge reports it with a one-cycle overrun pulse.

Top module: `i2s_sim_dac_bridge`

## Requirements
- R1: While reset is held and after it is released with no input activity, `dac_sclk`, `dac_data_l`, `dac_data_r`, `dac_le` and `overrun` are all 0.
- R2: Input words are captured on rising bit-clock edges, most significant bit first. The MSB arrives one bit clock after a word-select transition. Each slot is 16 bits, and word select 0 marks the left slot. A left/right pair is complete when the right slot's last bit is taken, at the next falling edge of word select.
- R3: Each pair is sent as exactly 16 rising edges of `dac_sclk`. The left word goes on `dac_data_l` and the right word on `dac_data_r`, MSB first. Data is valid at each rising edge. Each shift-clock half period is SCLK_HALF master cycles (default 1), and `dac_sclk` rests at 0 outside the burst.
- R4: The number of master cycles in which both `dac_sclk` and `dac_le` are 0, counted from the last shift-clock high cycle to the first strobe-high cycle, equals `settle_cycles`. A value of 0 is allowed.
- R5: `dac_le` stays high for `latch_cycles` master cycles. A value of 0 is treated as 1.
- R6: While `dac_le` is high, `dac_sclk` is 0 and neither data pin changes. A new burst never begins before the strobe has fallen.
- R7: After reset, `dac_le` does not rise until a full left-then-right pair has been received. A right slot seen without a preceding left slot is discarded.
- R8: When a pair completes before the previous pair's strobe has finished, `overrun` pulses high for one master cycle. The newest pair replaces any pair still waiting, and the older waiting pair is never sent.
- R9: Without overrun, pairs are sent and latched once each, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low reset |
| i2s_bck | input | 1 | I2S bit clock, oversampled by clk |
| i2s_ws | input | 1 | I2S word select, 0 = left |
| i2s_sd | input | 1 | I2S serial data |
| settle_cycles | input | CNT_W | Quiet master cycles between burst end and strobe |
| latch_cycles | input | CNT_W | Strobe width in master cycles (0 acts as 1) |
| dac_sclk | output | 1 | Shared shift clock to the DAC, idle low |
| dac_data_l | output | 1 | Left-channel serial data |
| dac_data_r | output | 1 | Right-channel serial data |
| dac_le | output | 1 | DAC latch strobe, active high |
| overrun | output | 1 | One-cycle pulse when a waiting pair is replaced |

## Verification
The bench rebuilds each burst from the shift-clock edges. This exposes a one-bit framing slip (a design that ignored the I2S delay would shift every word by a bit) and a left/right swap. It measures the quiet gap and the strobe width, including the zero-settle and zero-width settings. An off-by-one counter, or a strobe raised together with the last shift edge, shows up as a wrong cycle count. Overrun is forced with a settle wait longer than two frames: a design that queued rather than replaced pairs would latch the middle pair. The first-pair rule is exercised by leaving a frame's right slot incomplete, where an early strobe would appear.

// File: rtl/i2s_sim_pkg.sv
package i2s_sim_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_BURST  = 2'd1,
      SEQ_SETTLE = 2'd2,
      SEQ_LATCH  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/i2s_rx_capture.sv
module i2s_rx_capture #(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bck_in,
   input  logic              ws_in,
   input  logic              sd_in,
   output logic              pair_valid,
   output logic [WORD_W-1:0] left_word,
   output logic [WORD_W-1:0] right_word
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] bck_s, ws_s, sd_s;
   logic                   bck_last;
   logic                   bck_rise;
   logic [WORD_W-2:0]      shreg;
   logic                   ws_prev;
   logic                   left_seen;
   logic [WORD_W-1:0]      left_hold;
   logic [WORD_W-1:0]      word_now;

   // synchroniser chain, one flop per stage
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  bck_s[0] <= 1'b0;
                  ws_s[0]  <= 1'b1;
                  sd_s[0]  <= 1'b0;
               end else begin
                  bck_s[0] <= bck_in;
                  ws_s[0]  <= ws_in;
                  sd_s[0]  <= sd_in;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  bck_s[gi] <= 1'b0;
                  ws_s[gi]  <= 1'b1;
                  sd_s[gi]  <= 1'b0;
               end else begin
                  bck_s[gi] <= bck_s[gi-1];
                  ws_s[gi]  <= ws_s[gi-1];
                  sd_s[gi]  <= sd_s[gi-1];
               end
            end
         end
      end
   endgenerate

   assign bck_rise = bck_s[TOP] & ~bck_last;
   assign word_now = {shreg, sd_s[TOP]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bck_last   <= 1'b0;
         shreg      <= '0;
         ws_prev    <= 1'b1;
         left_seen  <= 1'b0;
         left_hold  <= '0;
         left_word  <= '0;
         right_word <= '0;
         pair_valid <= 1'b0;
      end else begin
         bck_last   <= bck_s[TOP];
         pair_valid <= 1'b0;
         if (bck_rise) begin
            shreg   <= word_now[WORD_W-2:0];
            ws_prev <= ws_s[TOP];
            if (ws_s[TOP] != ws_prev) begin
               // the bit taken at a word-select change is the LSB of the slot just ended
               if (!ws_prev) begin
                  left_hold <= word_now;
                  left_seen <= 1'b1;
               end else if (left_seen) begin
                  left_word  <= left_hold;
                  right_word <= word_now;
                  pair_valid <= 1'b1;
                  left_seen  <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/burst_shifter.sv
module burst_shifter #(
   parameter int WORD_W    = 16,
   parameter int SCLK_HALF = 1,
   parameter int LANES     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [LANES*WORD_W-1:0] load_words,
   output logic                    sclk,
   output logic [LANES-1:0]        sdata,
   output logic                    done
);
   localparam int BI_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [BI_W-1:0] LAST_BIT = BI_W'(WORD_W - 1);

   logic            active;
   logic            phase;
   logic [BI_W-1:0] bit_idx;
   logic            half_end;
   logic            last_edge;
   logic            shift_en;

   generate
      if (SCLK_HALF == 1) begin : g_half_one
         assign half_end = 1'b1;
      end else begin : g_half_cnt
         localparam int HC_W = $clog2(SCLK_HALF);
         logic [HC_W-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              hcnt <= '0;
            else if (start || !active || half_end)   hcnt <= '0;
            else                                     hcnt <= hcnt + 1'b1;
         end
         assign half_end = (hcnt == HC_W'(SCLK_HALF - 1));
      end
   endgenerate

   assign last_edge = active && half_end && phase && (bit_idx == LAST_BIT);
   assign shift_en  = active && half_end && phase && (bit_idx != LAST_BIT);
   assign done      = last_edge;
   assign sclk      = active & phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         phase   <= 1'b0;
         bit_idx <= '0;
      end else if (start) begin
         active  <= 1'b1;
         phase   <= 1'b0;
         bit_idx <= '0;
      end else if (active && half_end) begin
         if (!phase) begin
            phase <= 1'b1;
         end else begin
            phase <= 1'b0;
            if (bit_idx == LAST_BIT) active  <= 1'b0;
            else                     bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   // one shift register per lane, all sharing the same clock phase
   genvar li;
   generate
      for (li = 0; li < LANES; li++) begin : g_lane
         logic [WORD_W-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sh <= '0;
            else if (start)    sh <= load_words[li*WORD_W +: WORD_W];
            else if (shift_en) sh <= {sh[WORD_W-2:0], 1'b0};
         end
         assign sdata[li] = sh[WORD_W-1];
      end
   endgenerate
endmodule

// File: rtl/settle_latch_seq.sv
module settle_latch_seq
   import i2s_sim_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pair_valid,
   input  logic [WORD_W-1:0]   left_word,
   input  logic [WORD_W-1:0]   right_word,
   input  logic [CNT_W-1:0]    settle_cycles,
   input  logic [CNT_W-1:0]    latch_cycles,
   input  logic                burst_done,
   output logic                start,
   output logic [2*WORD_W-1:0] load_words,
   output logic                le,
   output logic                overrun
);
   seq_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  eff_latch;
   logic              pend_valid;
   logic [WORD_W-1:0] pend_l, pend_r;

   assign eff_latch  = (latch_cycles == '0) ? CNT_W'(1) : latch_cycles;
   assign start      = (state == SEQ_IDLE) && pend_valid;
   assign load_words = {pend_r, pend_l};   // lane 0 = left, lane 1 = right
   assign le         = (state == SEQ_LATCH);

   // second buffer stage: holds the pair waiting for the next burst
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_l     <= '0;
         pend_r     <= '0;
         overrun    <= 1'b0;
      end else begin
         overrun <= pair_valid && ((state != SEQ_IDLE) || pend_valid);
         if (pair_valid) begin
            pend_l     <= left_word;
            pend_r     <= right_word;
            pend_valid <= 1'b1;
         end else if (start) begin
            pend_valid <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               cnt <= '0;
               if (start) state <= SEQ_BURST;
            end
            SEQ_BURST: begin
               cnt <= '0;
               if (burst_done) state <= (settle_cycles == '0) ? SEQ_LATCH : SEQ_SETTLE;
            end
            SEQ_SETTLE: begin
               if (cnt == settle_cycles - CNT_W'(1)) begin
                  state <= SEQ_LATCH;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_LATCH: begin
               if (cnt == eff_latch - CNT_W'(1)) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2s_sim_dac_bridge.sv
module i2s_sim_dac_bridge #(
   parameter int WORD_W      = 16,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SCLK_HALF   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i2s_bck,
   input  logic             i2s_ws,
   input  logic             i2s_sd,
   input  logic [CNT_W-1:0] settle_cycles,
   input  logic [CNT_W-1:0] latch_cycles,
   output logic             dac_sclk,
   output logic             dac_data_l,
   output logic             dac_data_r,
   output logic             dac_le,
   output logic             overrun
);
   localparam int LANES = 2;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("WORD_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SCLK_HALF < 1) begin : g_bad_half
         $error("SCLK_HALF must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic                    pair_valid;
   logic [WORD_W-1:0]       left_word, right_word;
   logic                    start, burst_done;
   logic [LANES*WORD_W-1:0] load_words;
   logic [LANES-1:0]        sdata;

   i2s_rx_capture #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .bck_in(i2s_bck), .ws_in(i2s_ws), .sd_in(i2s_sd),
      .pair_valid(pair_valid), .left_word(left_word), .right_word(right_word)
   );

   settle_latch_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .pair_valid(pair_valid), .left_word(left_word), .right_word(right_word),
      .settle_cycles(settle_cycles), .latch_cycles(latch_cycles),
      .burst_done(burst_done), .start(start), .load_words(load_words),
      .le(dac_le), .overrun(overrun)
   );

   burst_shifter #(.WORD_W(WORD_W), .SCLK_HALF(SCLK_HALF), .LANES(LANES)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .load_words(load_words),
      .sclk(dac_sclk), .sdata(sdata), .done(burst_done)
   );

   assign dac_data_l = sdata[0];
   assign dac_data_r = sdata[1];
endmodule

// File: rtl/i2s_sim_dac_bridge_chk.sv
module i2s_sim_dac_bridge_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dac_sclk,
   input logic             dac_data_l,
   input logic             dac_data_r,
   input logic             dac_le,
   input logic             overrun,
   input logic [CNT_W-1:0] latch_cycles
);
   logic [CNT_W-1:0] le_run;
   logic [CNT_W-1:0] eff;
   logic             seen_sclk;

   assign eff = (latch_cycles == '0) ? CNT_W'(1) : latch_cycles;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         le_run    <= '0;
         seen_sclk <= 1'b0;
      end else begin
         le_run <= dac_le ? le_run + 1'b1 : '0;
         if (dac_sclk) seen_sclk <= 1'b1;
      end
   end

   p_le_sclk_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_le |-> !dac_sclk);

   p_data_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_le |-> ($stable(dac_data_l) && $stable(dac_data_r)));

   p_le_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dac_le |-> (le_run < eff));

   p_no_early_le_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dac_le |-> seen_sclk);

   p_overrun_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> !overrun);
endmodule

bind i2s_sim_dac_bridge i2s_sim_dac_bridge_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dac_sclk(dac_sclk), .dac_data_l(dac_data_l),
   .dac_data_r(dac_data_r), .dac_le(dac_le), .overrun(overrun),
   .latch_cycles(latch_cycles)
);

// File: tb/i2s_sim_dac_bridge_bench.sv
module i2s_sim_dac_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bck = 1'b0, ws = 1'b1, sd = 1'b0;
   logic [15:0] settle = 16'd20, latch = 16'd5;
   logic        sclk, dl, dr, le, ovr;

   always #5 clk = ~clk;

   i2s_sim_dac_bridge u_i2s_sim_dac_bridge (
      .clk(clk), .rst_n(rst_n), .i2s_bck(bck), .i2s_ws(ws), .i2s_sd(sd),
      .settle_cycles(settle), .latch_cycles(latch),
      .dac_sclk(sclk), .dac_data_l(dl), .dac_data_r(dr), .dac_le(le), .overrun(ovr)
   );

   int tests = 0, fails = 0;
   logic prev_rlsb = 1'b0;

   // monitor state
   int   n_lat, bits, gap, wcnt, hi_run, hi_bad, viol, ov_cnt;
   int   log_bits [0:15];
   int   log_gap  [0:15];
   int   log_w    [0:15];
   logic [15:0] cap_l, cap_r;
   logic [15:0] log_l [0:15];
   logic [15:0] log_r [0:15];
   logic p_sclk, p_le, p_dl, p_dr;

   always @(negedge clk) begin
      if (!rst_n) begin
         n_lat = 0; bits = 0; gap = 0; wcnt = 0; hi_run = 0; hi_bad = 0;
         viol = 0; ov_cnt = 0; cap_l = '0; cap_r = '0;
         p_sclk = 0; p_le = 0; p_dl = 0; p_dr = 0;
      end else begin
         if (sclk && !p_sclk) begin
            cap_l = {cap_l[14:0], dl};
            cap_r = {cap_r[14:0], dr};
            bits++;
         end
         if (sclk) begin hi_run++; gap = 0; end
         else begin
            if (p_sclk && hi_run != 1) hi_bad++;
            hi_run = 0;
            if (!le) gap++;
         end
         if (le && !p_le && n_lat < 16) begin
            log_l[n_lat] = cap_l; log_r[n_lat] = cap_r;
            log_bits[n_lat] = bits; log_gap[n_lat] = gap;
            bits = 0;
         end
         if (le) wcnt++;
         if (!le && p_le && n_lat < 16) begin
            log_w[n_lat] = wcnt; wcnt = 0; n_lat++;
         end
         if (le && (sclk || dl != p_dl || dr != p_dr)) viol++;
         if (ovr) ov_cnt++;
         p_sclk = sclk; p_le = le; p_dl = dl; p_dr = dr;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bck = 1'b0; ws = 1'b1; sd = 1'b0; prev_rlsb = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_bit(input logic w, input logic d);
      @(negedge clk);
      bck = 1'b0; ws = w; sd = d;
      repeat (3) @(negedge clk);
      bck = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input logic [15:0] l, input logic [15:0] r);
      for (int j = 0; j < 32; j++) begin
         logic d;
         if (j == 0)       d = prev_rlsb;
         else if (j <= 16) d = l[16-j];
         else              d = r[32-j];
         send_bit(j >= 16, d);
      end
      prev_rlsb = r[0];
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check({sclk, dl, dr, le, ovr} == 5'b0, "R1 in reset", {sclk, dl, dr, le, ovr}, 0);
      do_reset();
      repeat (20) @(negedge clk);
      check({sclk, dl, dr, le, ovr} == 5'b0, "R1 after reset", {sclk, dl, dr, le, ovr}, 0);
   endtask

   task automatic t_basic();
      settle = 16'd20; latch = 16'd5;
      do_reset();
      send_frame(16'hA5C3, 16'h3C5A);
      repeat (100) @(negedge clk);
      check(n_lat == 0 && !le, "R7 no latch before pair complete", n_lat, 0);
      send_frame(16'h0000, 16'h0000);
      repeat (100) @(negedge clk);
      check(n_lat == 1, "R9 one latch", n_lat, 1);
      check(log_l[0] == 16'hA5C3, "R2 left word", log_l[0], 16'hA5C3);
      check(log_r[0] == 16'h3C5A, "R3 right word", log_r[0], 16'h3C5A);
      check(log_bits[0] == 16, "R3 shift edges", log_bits[0], 16);
      check(hi_bad == 0, "R3 sclk half period", hi_bad, 0);
      check(log_gap[0] == 20, "R4 settle gap", log_gap[0], 20);
      check(log_w[0] == 5, "R5 latch width", log_w[0], 5);
      check(viol == 0, "R6 quiet during latch", viol, 0);
   endtask

   task automatic t_stream();
      logic [15:0] el [0:2];
      logic [15:0] er [0:2];
      el[0] = 16'h0000; er[0] = 16'hFFFF;
      el[1] = 16'h8001; er[1] = 16'h7FFE;
      el[2] = 16'h1234; er[2] = 16'hFEDC;
      settle = 16'd7; latch = 16'd3;
      do_reset();
      for (int k = 0; k < 3; k++) send_frame(el[k], er[k]);
      send_frame(16'h0, 16'h0);
      repeat (100) @(negedge clk);
      check(n_lat == 3, "R9 latch count", n_lat, 3);
      for (int k = 0; k < 3; k++) begin
         check(log_l[k] == el[k], "R9 left order", log_l[k], el[k]);
         check(log_r[k] == er[k], "R9 right order", log_r[k], er[k]);
         check(log_gap[k] == 7, "R4 gap", log_gap[k], 7);
         check(log_w[k] == 3, "R5 width", log_w[k], 3);
      end
      check(ov_cnt == 0, "R8 no false overrun", ov_cnt, 0);
      check(viol == 0, "R6 quiet", viol, 0);
   endtask

   task automatic t_zero();
      settle = 16'd0; latch = 16'd0;
      do_reset();
      send_frame(16'hFFFF, 16'h0001);
      send_frame(16'h0, 16'h0);
      repeat (100) @(negedge clk);
      check(n_lat == 1, "R9 latch count zero cfg", n_lat, 1);
      check(log_gap[0] == 0, "R4 zero settle", log_gap[0], 0);
      check(log_w[0] == 1, "R5 zero width acts as one", log_w[0], 1);
      check(log_l[0] == 16'hFFFF && log_r[0] == 16'h0001, "R3 data zero cfg",
            {log_l[0], log_r[0]}, 32'hFFFF0001);
      check(viol == 0, "R6 quiet zero cfg", viol, 0);
   endtask

   task automatic t_overrun();
      settle = 16'd600; latch = 16'd4;
      do_reset();
      send_frame(16'h1111, 16'h2222);
      send_frame(16'h3333, 16'h4444);
      send_frame(16'h5555, 16'h6666);
      send_frame(16'h7777, 16'h8888);
      repeat (1400) @(negedge clk);
      check(ov_cnt == 2, "R8 overrun pulses", ov_cnt, 2);
      check(n_lat == 2, "R8 latch count", n_lat, 2);
      check(log_l[0] == 16'h1111 && log_r[0] == 16'h2222, "R8 first pair",
            {log_l[0], log_r[0]}, 32'h11112222);
      check(log_l[1] == 16'h5555 && log_r[1] == 16'h6666, "R8 newest kept",
            {log_l[1], log_r[1]}, 32'h55556666);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_stream();
      t_zero();
      t_overrun();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule